// File: doc/BRIEF.md
# Two-Wire Control Register Target

This block is the control-port end of a mixed-signal front end. It listens on a two-wire I2C bus as a target with a fixed 7-bit address and holds three small control registers. It drives the register fields straight out as static control lines: a power enable, an input selector code, a serial-format select, a clock-mode code and a soft-mute request. The bus pins are sampled on a fast system clock through two-flop synchronisers. SDA is driven only as an open-drain pull-down through an output enable.

A controller writes by sending the target address with the direction bit clear. It then sends a register index, followed by any number of data bytes. A 2-bit pointer steps after every data byte and wraps from index 2 back to index 0. Reads come in two kinds. A current-address read continues from the pointer left by the last access, whether that access was a read or a write. A random read sets the pointer with a short write and then issues a repeated start. Bits that belong to no field read back as zero and ignore written values.

Top module: `i2c_ctrl_regfile`

## Requirements
- R1: While `rst_n` is low and right after it rises, the outputs take their defaults: `pwr_on`=1, `in_sel`=3'b100, `fmt_i2s`=0, `clk_mode`=0, `soft_mute`=0, and `sda_oe`=0. The pointer is reset to index 0.
- R2: The target acknowledges a first byte only when its upper seven bits equal `DEV_ADDR` (default 7'b0110001). Bit 0 of that byte is the direction: 0 means write, 1 means read. Any other address is not acknowledged, and the rest of that transfer is ignored.
- R3: In a write, the byte after the address sets the pointer from its two low bits. Each later byte is written to the register at the pointer, and the pointer then advances. Every byte is acknowledged. Fields change only when a written byte is taken in.
- R4: When the pointer advances from index 2 (or from index 3), it goes to index 0. A long burst therefore overwrites the registers written earlier in that burst.
- R5: The field layout is: index 0 bit 0 = `pwr_on`; index 1 bits 2:0 = `in_sel`; index 2 bit 4 = `fmt_i2s`, bits 3:1 = `clk_mode`, bit 0 = `soft_mute`. All other bits read 0, and writes to them have no effect. Index 3 reads 0x00, and writes to it are ignored.
- R6: A random read is a pointer write, then a repeated start with the direction bit set. It returns the register at that index first, then the registers that follow, for as long as the controller acknowledges.
- R7: A read that starts with a new start condition and no pointer byte returns the register at the current pointer. That pointer is the one after the last byte read or written.
- R8: After the controller answers a read byte with a not-acknowledge, the target releases SDA and drives nothing until the next start. In the idle state the target never drives SDA.
- R9: Clearing `pwr_on` leaves the other registers unchanged, and they stay writable.
- R10: Pulling `rst_n` low in the middle of a transfer returns all fields and the pointer to their defaults.
- R11: The target changes `sda_oe` only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| pwr_on | output | 1 | Power enable field |
| in_sel | output | 3 | Input selector code |
| fmt_i2s | output | 1 | Serial format select |
| clk_mode | output | 3 | Clock-mode code |
| soft_mute | output | 1 | Soft-mute request |

## Verification
The bench builds the block with its default `DEV_ADDR` of 7'b0110001. This lets it test acceptance and also rejection of a neighbouring address that differs in the low two bits. It runs SCL at one fortieth of the system clock. That leaves room to check the acknowledge and read bits with the synchroniser delay counted in. Because the index is only two bits wide, random bursts of up to five bytes repeatedly reach the wrap from index 2 and the unused index 3.

// File: rtl/i2c_ctrl_regfile.sv
module i2c_ctrl_regfile #(
  parameter logic [6:0] DEV_ADDR = 7'b0110001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       pwr_on,
  output logic [2:0] in_sel,
  output logic       fmt_i2s,
  output logic [2:0] clk_mode,
  output logic       soft_mute
);

  typedef enum logic [3:0] {
    S_IDLE = 4'd0, S_ADDR = 4'd1, S_AACK = 4'd2, S_PTR = 4'd3, S_PACK = 4'd4,
    S_WDAT = 4'd5, S_WACK = 4'd6, S_RDAT = 4'd7, S_RACK = 4'd8
  } st_t;

  st_t        st;
  logic       scl_m, sda_m, scl_s, sda_s, scl_q, sda_q;
  logic [2:0] bcnt;
  logic [7:0] shr;
  logic       got8, rw, mack;
  logic [1:0] ptr;
  logic       pwn;
  logic [2:0] sel;
  logic [4:0] ctl;
  logic [7:0] rd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {scl_m, scl_s, scl_q} <= 3'b111;
      {sda_m, sda_s, sda_q} <= 3'b111;
    end else begin
      {scl_m, scl_s, scl_q} <= {scl_i, scl_m, scl_s};
      {sda_m, sda_s, sda_q} <= {sda_i, sda_m, sda_s};
    end
  end

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  function automatic logic [1:0] nxt(input logic [1:0] p);
    return (p >= 2'd2) ? 2'd0 : p + 2'd1;
  endfunction

  always_comb begin
    case (ptr)
      2'd0:    rd_byte = {7'd0, pwn};
      2'd1:    rd_byte = {5'd0, sel};
      2'd2:    rd_byte = {3'd0, ctl};
      default: rd_byte = 8'd0;
    endcase
  end

  assign pwr_on    = pwn;
  assign in_sel    = sel;
  assign fmt_i2s   = ctl[4];
  assign clk_mode  = ctl[3:1];
  assign soft_mute = ctl[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      bcnt   <= '0;
      shr    <= '0;
      got8   <= 1'b0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      ptr    <= '0;
      pwn    <= 1'b1;
      sel    <= 3'b100;
      ctl    <= '0;
    end else if (start_c) begin
      st     <= S_ADDR;
      bcnt   <= '0;
      got8   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_PTR, S_WDAT: begin
          if (scl_rise) begin
            shr  <= {shr[6:0], sda_s};
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) got8 <= 1'b1;
          end else if (scl_fall && got8) begin
            got8 <= 1'b0;
            if (st == S_ADDR) begin
              if (shr[7:1] == DEV_ADDR) begin
                rw     <= shr[0];
                sda_oe <= 1'b1;
                st     <= S_AACK;
              end else begin
                st <= S_IDLE;
              end
            end else if (st == S_PTR) begin
              ptr    <= shr[1:0];
              sda_oe <= 1'b1;
              st     <= S_PACK;
            end else begin
              case (ptr)
                2'd0:    pwn <= shr[0];
                2'd1:    sel <= shr[2:0];
                2'd2:    ctl <= shr[4:0];
                default: ;
              endcase
              ptr    <= nxt(ptr);
              sda_oe <= 1'b1;
              st     <= S_WACK;
            end
          end
        end
        S_AACK: if (scl_fall) begin
          bcnt <= '0;
          if (rw) begin
            shr    <= rd_byte;
            sda_oe <= ~rd_byte[7];
            ptr    <= nxt(ptr);
            st     <= S_RDAT;
          end else begin
            sda_oe <= 1'b0;
            st     <= S_PTR;
          end
        end
        S_PACK, S_WACK: if (scl_fall) begin
          bcnt   <= '0;
          sda_oe <= 1'b0;
          st     <= S_WDAT;
        end
        S_RDAT: if (scl_fall) begin
          if (bcnt == 3'd7) begin
            sda_oe <= 1'b0;
            mack   <= 1'b0;
            st     <= S_RACK;
          end else begin
            shr    <= {shr[6:0], 1'b0};
            sda_oe <= ~shr[6];
            bcnt   <= bcnt + 3'd1;
          end
        end
        S_RACK: begin
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) begin
            if (mack) begin
              shr    <= rd_byte;
              sda_oe <= ~rd_byte[7];
              ptr    <= nxt(ptr);
              bcnt   <= '0;
              st     <= S_RDAT;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_ctrl_regfile_chk.sv
module i2c_ctrl_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic [3:0] st,
  input logic       pwr_on,
  input logic [2:0] in_sel,
  input logic       fmt_i2s,
  input logic [2:0] clk_mode,
  input logic       soft_mute
);

  wire [8:0] fields = {pwr_on, in_sel, fmt_i2s, clk_mode, soft_mute};

  assert_reset_defaults_R1: assert property (@(posedge clk)
    !rst_n |=> (fields == 9'b1_100_0_000_0 && !sda_oe));

  assert_write_on_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fields) |-> (st == 4'd6));

  assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd0) |-> !sda_oe);

  assert_sda_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

endmodule

bind i2c_ctrl_regfile i2c_ctrl_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .st(st),
  .pwr_on(pwr_on), .in_sel(in_sel), .fmt_i2s(fmt_i2s), .clk_mode(clk_mode),
  .soft_mute(soft_mute)
);

// File: tb/i2c_ctrl_regfile_tb.sv
module i2c_ctrl_regfile_tb;
  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, pwr_on, fmt_i2s, soft_mute;
  logic [2:0] in_sel, clk_mode;
  logic sda_bus;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] mem [4];
  logic [1:0] mptr;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_ctrl_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .pwr_on(pwr_on), .in_sel(in_sel), .fmt_i2s(fmt_i2s), .clk_mode(clk_mode),
    .soft_mute(soft_mute)
  );

  function automatic logic [7:0] msk(input logic [1:0] i, input logic [7:0] v);
    case (i)
      2'd0:    return {7'd0, v[0]};
      2'd1:    return {5'd0, v[2:0]};
      2'd2:    return {3'd0, v[4:0]};
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [1:0] mnext(input logic [1:0] p);
    return (p >= 2'd2) ? 2'd0 : p + 2'd1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag);
    logic [8:0] e, a;
    e = {mem[0][0], mem[1][2:0], mem[2][4], mem[2][3:1], mem[2][0]};
    a = {pwr_on, in_sel, fmt_i2s, clk_mode, soft_mute};
    chk(a == e, tag, a, e);
  endtask

  task automatic q; repeat (10) @(negedge clk); endtask

  task automatic i2c_start;
    sda_m = 1; q; scl_m = 1; q; sda_m = 0; q; scl_m = 0; q;
  endtask

  task automatic i2c_stop;
    sda_m = 0; q; scl_m = 1; q; sda_m = 1; q;
  endtask

  task automatic wbit(input logic b);
    sda_m = b; q; scl_m = 1; q; q; scl_m = 0; q;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    sda_m = 1; q; scl_m = 1; q; ack = !sda_bus; q; scl_m = 0; q;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sda_m = 1; q; scl_m = 1; q; b = {b[6:0], sda_bus}; q; scl_m = 0; q;
    end
    wbit(!ack);
    sda_m = 1;
  endtask

  task automatic wr_burst(input logic [1:0] p, input int n, input logic [7:0] d0, input bit rnd);
    bit ack;
    logic [7:0] d;
    i2c_start;
    send_byte(8'h62, ack); chk(ack, "R2 address ack", ack, 1);
    send_byte({6'd0, p}, ack); chk(ack, "R3 pointer ack", ack, 1);
    mptr = p;
    for (int k = 0; k < n; k++) begin
      d = rnd ? 8'($urandom) : d0;
      send_byte(d, ack); chk(ack, "R3 data ack", ack, 1);
      mem[mptr] = msk(mptr, d);
      mptr = mnext(mptr);
    end
    i2c_stop;
    chk_out("R3 fields after write");
  endtask

  task automatic rd_bytes(input int n, input string tag);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      chk(b == mem[mptr], tag, b, mem[mptr]);
      mptr = mnext(mptr);
    end
    repeat (5) @(negedge clk);
    chk(!sda_oe, "R8 released after nack", sda_oe, 0);
    i2c_stop;
  endtask

  task automatic rd_cur(input int n);
    bit ack;
    i2c_start;
    send_byte(8'h63, ack); chk(ack, "R2 read address ack", ack, 1);
    rd_bytes(n, "R7 current read");
  endtask

  task automatic rd_rand(input logic [1:0] p, input int n);
    bit ack;
    i2c_start;
    send_byte(8'h62, ack); chk(ack, "R2 address ack", ack, 1);
    send_byte({6'd0, p}, ack); chk(ack, "R6 pointer ack", ack, 1);
    mptr = p;
    i2c_start;
    send_byte(8'h63, ack); chk(ack, "R6 read address ack", ack, 1);
    rd_bytes(n, "R6 random read");
  endtask

  task automatic model_reset;
    mem[0] = 8'h01; mem[1] = 8'h04; mem[2] = 8'h00; mem[3] = 8'h00; mptr = 0;
  endtask

  initial begin
    bit ack;
    void'($urandom(32'd1234));
    model_reset;
    repeat (20) @(negedge clk);
    chk_out("R1 defaults in reset");
    chk(!sda_oe, "R1 sda released in reset", sda_oe, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    chk_out("R1 defaults after reset");

    // R2: neighbouring address is ignored
    i2c_start;
    send_byte(8'h64, ack); chk(!ack, "R2 wrong address nack", ack, 0);
    send_byte(8'h01, ack); chk(!ack, "R2 ignored pointer", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R2 ignored data", ack, 0);
    i2c_stop;
    chk_out("R2 fields untouched");

    // R5: reserved bits
    wr_burst(2'd0, 1, 8'hFE, 0);
    wr_burst(2'd1, 2, 8'hFF, 0);
    chk_out("R5 reserved bits ignored");
    rd_rand(2'd0, 3);

    // R4: wrap from 2 to 0
    wr_burst(2'd1, 4, 8'h00, 1);
    chk_out("R4 wrap overwrite");
    rd_cur(2);
    rd_cur(1);

    // R5: index 3
    wr_burst(2'd3, 2, 8'h00, 1);
    chk(mptr == 2'd1, "R4 pointer after index 3", mptr, 1);
    rd_rand(2'd3, 2);

    // R9: power bit clear keeps other registers
    wr_burst(2'd0, 1, 8'h00, 0);
    chk_out("R9 power cleared others kept");
    wr_burst(2'd1, 2, 8'h00, 1);
    chk_out("R9 writable while powered down");

    // R10: reset in mid transfer
    i2c_start;
    send_byte(8'h62, ack);
    send_byte(8'h02, ack);
    rst_n = 0;
    repeat (4) @(negedge clk);
    model_reset;
    chk_out("R10 defaults on mid-transfer reset");
    rst_n = 1;
    i2c_stop;
    rd_cur(1);

    for (int t = 0; t < 30; t++) begin
      case ($urandom_range(2, 0))
        0: wr_burst(2'($urandom), $urandom_range(5, 1), 8'h00, 1);
        1: rd_cur($urandom_range(4, 1));
        default: rd_rand(2'($urandom), $urandom_range(4, 1));
      endcase
    end
    chk_out("R3 final fields");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule